// File: doc/BRIEF.md
# Debug Register Scan Chain

This block is a bank of debug registers that a JTAG debugger reaches through one 38-bit data scan chain. The TAP state decode sits outside the block, which receives three one-hot strobes: capture, shift and update. Each scanned word carries three things:

- a 32-bit data value, shifted in and out first, least significant bit first;
- a 5-bit register address;
- a direction flag in the last bit.

A write takes effect when the update strobe arrives. A read takes two scans. The first scan names the register. The capture at the start of the next scan loads that register into the data field, and the following shifts move it out.

The bank holds the following registers:

- a debug control register, which drives an output;
- a read-only debug status register, which mirrors an input;
- a two-way mailbox between debugger and core, with a control word and a data word;
- two watchpoint comparators, each with value/mask pairs for address, data and bus control.

The core side of the mailbox uses a ready/valid handshake in each direction. When the debugger captures the mailbox data word, the "data waiting" flag clears. For that reason, the trailing scan of a read should name the mailbox control word, whose capture has no side effect.

Top module: `dbg_regscan`

## Requirements
- R1: The scan register is 38 bits. `tdo` always shows bit 0. On each shift strobe, the register moves one place toward bit 0 and `tdi` enters at bit 37. Bits [31:0] are data, bits [36:32] are the address, and bit 37 is the direction flag. A word shifted in is therefore presented data LSB first, then the address LSB first, then the flag.
- R2: On an update strobe with bit 37 = 1, the 32-bit data is written to the addressed register. A write to address 0x00 appears on `dbg_ctrl` one cycle later.
- R3: On an update strobe with bit 37 = 0, the address is held as the read source. The next capture strobe loads that register's value into bits [31:0] and zeros into bits [37:32].
- R4: The address map is as follows:
  - 0x00 is debug control, read/write.
  - 0x01 is debug status. It reads `dbg_status`, and writes to it are ignored.
  - 0x04 is mailbox control.
  - 0x05 is mailbox data.
  - Watchpoint 0 uses 0x08–0x0D and watchpoint 1 uses 0x10–0x15. In each unit the six registers are, in rising order: address value, address mask, data value, data mask, control value, control mask.
- R5: Mailbox control reads bit 0 = core-to-debugger data waiting, bit 1 = debugger-to-core data pending, bits [27:2] = 0, and bits [31:28] = the `VERSION` parameter (default 0x3). Writes to it are ignored.
- R6: A capture with mailbox data (0x05) as the read source clears the waiting flag. A capture of mailbox control leaves the flag unchanged. If a read source of 0x05 is left in place, the next scan's capture performs a second, destructive read.
- R7: A debugger write to 0x05 loads `d2c_data` and raises `d2c_valid`. A cycle with `d2c_valid` and `d2c_ready` both high drops `d2c_valid`, unless a debugger write to 0x05 lands in the same cycle, in which case the write wins.
- R8: `c2d_ready` is high exactly while no core data is waiting. A cycle with `c2d_valid` and `c2d_ready` both high stores `c2d_data` for the debugger and drops `c2d_ready`.
- R9: A write to an unmapped address (for example 0x07, 0x0E or 0x1F) changes nothing, and a read of one returns zero.
- R10: `rst_n` or `trst_n` low clears every register and flag; the version field is kept. With no strobe high, `tdo` and the scan register hold.
- R11: Watchpoint unit u asserts `wp_match[u]` when all three of these terms are zero: `(bus_addr ^ addr value) & ~addr mask`, the same term for data, and the same term for bus control.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock; all state changes on its rising edge |
| rst_n | input | 1 | System reset, active low, asynchronous |
| trst_n | input | 1 | Test logic reset, active low, asynchronous |
| capture_dr | input | 1 | Capture strobe for this chain |
| shift_dr | input | 1 | Shift strobe for this chain |
| update_dr | input | 1 | Update strobe for this chain |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (scan register bit 0) |
| dbg_ctrl | output | 32 | Debug control register contents |
| dbg_status | input | 32 | Value returned for debug status reads |
| c2d_data | input | 32 | Core-to-debugger word |
| c2d_valid | input | 1 | Core offers a word |
| c2d_ready | output | 1 | Mailbox can accept a core word |
| d2c_data | output | 32 | Debugger-to-core word |
| d2c_valid | output | 1 | A debugger word is pending for the core |
| d2c_ready | input | 1 | Core takes the pending word |
| bus_addr | input | 32 | Observed bus address |
| bus_data | input | 32 | Observed bus data |
| bus_ctrl | input | 32 | Observed bus control field |
| wp_match | output | 2 | Per-unit watchpoint match |

## Verification
The hardest situation to reach is the hidden second read. A read of mailbox data leaves 0x05 as the read source. The core then refills the mailbox, and the next unrelated scan's capture consumes the new word without the debugger asking for it. The stimulus reaches this state in five steps:

1. Two back-to-back scans name 0x05.
2. A core handshake is injected between scans.
3. A further scan names control. Its capture returns the new core word and frees `c2d_ready`.
4. A normal read of 0x05 with a trailing control scan is repeated.
5. The waiting flag is shown to survive control captures.

The same-cycle collision on R7 also needs care. The core's `d2c_ready` is raised only during the update strobe of a second mailbox write.

// File: rtl/dbg_regscan.sv
module dbg_regscan #(
  parameter int          DATA_W  = 32,
  parameter int          ADDR_W  = 5,
  parameter int          NUM_WP  = 2,
  parameter logic [3:0]  VERSION = 4'h3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trst_n,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  output logic              tdo,
  output logic [DATA_W-1:0] dbg_ctrl,
  input  logic [DATA_W-1:0] dbg_status,
  input  logic [DATA_W-1:0] c2d_data,
  input  logic              c2d_valid,
  output logic              c2d_ready,
  output logic [DATA_W-1:0] d2c_data,
  output logic              d2c_valid,
  input  logic              d2c_ready,
  input  logic [DATA_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [DATA_W-1:0] bus_ctrl,
  output logic [NUM_WP-1:0] wp_match
);
  localparam int SR_W    = DATA_W + ADDR_W + 1;
  localparam int WP_REGS = 6;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MCTL = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_MDAT = ADDR_W'(5);

  logic              arst_n;
  logic [SR_W-1:0]   sr_q;
  logic [ADDR_W-1:0] rd_src_q;
  logic [DATA_W-1:0] ctrl_q, c2d_q, d2c_q, rd_val;
  logic              wait_q, pend_q;
  logic [DATA_W-1:0] wp_q [NUM_WP][WP_REGS];

  wire [DATA_W-1:0] sr_data = sr_q[DATA_W-1:0];
  wire [ADDR_W-1:0] sr_addr = sr_q[DATA_W +: ADDR_W];
  wire              sr_wr   = sr_q[SR_W-1];
  wire              do_wr   = update_dr && sr_wr;
  wire              c2d_hs  = c2d_valid && c2d_ready;
  wire              d2c_hs  = d2c_valid && d2c_ready;

  assign arst_n    = rst_n & trst_n;
  assign tdo       = sr_q[0];
  assign dbg_ctrl  = ctrl_q;
  assign c2d_ready = !wait_q;
  assign d2c_data  = d2c_q;
  assign d2c_valid = pend_q;

  always_comb begin
    rd_val = '0;
    case (rd_src_q)
      A_CTRL: rd_val = ctrl_q;
      A_STAT: rd_val = dbg_status;
      A_MCTL: rd_val = {VERSION, {(DATA_W-6){1'b0}}, pend_q, wait_q};
      A_MDAT: rd_val = c2d_q;
      default: begin
        for (int u = 0; u < NUM_WP; u++)
          for (int k = 0; k < WP_REGS; k++)
            if (int'(rd_src_q) == (u + 1) * 8 + k) rd_val = wp_q[u][k];
      end
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sr_q     <= '0;
      rd_src_q <= '0;
      ctrl_q   <= '0;
      c2d_q    <= '0;
      d2c_q    <= '0;
      wait_q   <= 1'b0;
      pend_q   <= 1'b0;
      for (int u = 0; u < NUM_WP; u++)
        for (int k = 0; k < WP_REGS; k++) wp_q[u][k] <= '0;
    end else begin
      if (capture_dr)    sr_q <= {{(ADDR_W+1){1'b0}}, rd_val};
      else if (shift_dr) sr_q <= {tdi, sr_q[SR_W-1:1]};

      if (update_dr && !sr_wr)          rd_src_q <= sr_addr;
      if (do_wr && sr_addr == A_CTRL)   ctrl_q   <= sr_data;

      if (d2c_hs) pend_q <= 1'b0;
      if (do_wr && sr_addr == A_MDAT) begin
        d2c_q  <= sr_data;
        pend_q <= 1'b1;
      end

      if (capture_dr && rd_src_q == A_MDAT) wait_q <= 1'b0;
      if (c2d_hs) begin
        c2d_q  <= c2d_data;
        wait_q <= 1'b1;
      end

      for (int u = 0; u < NUM_WP; u++)
        for (int k = 0; k < WP_REGS; k++)
          if (do_wr && int'(sr_addr) == (u + 1) * 8 + k) wp_q[u][k] <= sr_data;
    end
  end

  for (genvar u = 0; u < NUM_WP; u++) begin : g_wp
    assign wp_match[u] = ~|((bus_addr ^ wp_q[u][0]) & ~wp_q[u][1])
                       & ~|((bus_data ^ wp_q[u][2]) & ~wp_q[u][3])
                       & ~|((bus_ctrl ^ wp_q[u][4]) & ~wp_q[u][5]);
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!arst_n)
    $onehot0({capture_dr, shift_dr, update_dr}));                                   // R1
  AST_SHIFT_OUT: assert property (@(posedge clk) disable iff (!arst_n)
    shift_dr |=> tdo == $past(sr_q[1]));                                            // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
    !(capture_dr || shift_dr || update_dr) |=> $stable(tdo));                       // R10
  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!arst_n)
    (do_wr && sr_addr == A_CTRL) |=> dbg_ctrl == $past(sr_data));                  // R2
  AST_CAPTURE_CLEARS: assert property (@(posedge clk) disable iff (!arst_n)
    (capture_dr && rd_src_q == A_MDAT && !c2d_ready) |=> c2d_ready);               // R6
  AST_C2D_LOAD: assert property (@(posedge clk) disable iff (!arst_n)
    c2d_hs |=> !c2d_ready);                                                         // R8
  AST_D2C_POST: assert property (@(posedge clk) disable iff (!arst_n)
    (do_wr && sr_addr == A_MDAT) |=> d2c_valid);                                    // R7
  AST_D2C_TAKE: assert property (@(posedge clk) disable iff (!arst_n)
    (d2c_hs && !(do_wr && sr_addr == A_MDAT)) |=> !d2c_valid);                      // R7
endmodule

// File: tb/dbg_regscan_tb.sv
`timescale 1ns/1ps
module dbg_regscan_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0, trst_n = 1'b1;
  logic cap = 1'b0, sh = 1'b0, upd = 1'b0, tdi = 1'b0;
  logic tdo;
  logic [31:0] dbg_ctrl, dbg_status = '0;
  logic [31:0] c2d_data = '0;
  logic c2d_valid = 1'b0, c2d_ready;
  logic [31:0] d2c_data;
  logic d2c_valid, d2c_ready = 1'b0;
  logic [31:0] bus_addr = '0, bus_data = '0, bus_ctrl = '0;
  logic [1:0] wp_match;

  int total = 0, bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  dbg_regscan u_dut (
    .clk(clk), .rst_n(rst_n), .trst_n(trst_n),
    .capture_dr(cap), .shift_dr(sh), .update_dr(upd), .tdi(tdi), .tdo(tdo),
    .dbg_ctrl(dbg_ctrl), .dbg_status(dbg_status),
    .c2d_data(c2d_data), .c2d_valid(c2d_valid), .c2d_ready(c2d_ready),
    .d2c_data(d2c_data), .d2c_valid(d2c_valid), .d2c_ready(d2c_ready),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_ctrl(bus_ctrl),
    .wp_match(wp_match)
  );

  // behavioural reference
  logic [37:0] m_sr;
  logic [4:0]  m_src;
  logic [31:0] m_reg [32];
  logic [31:0] m_c2d, m_d2c;
  logic        m_wait, m_pend;

  function automatic logic [31:0] m_read(input int a);
    if (a == 0) return m_reg[0];
    if (a == 1) return dbg_status;
    if (a == 4) return 32'h3000_0000 | (32'(m_pend) << 1) | 32'(m_wait);
    if (a == 5) return m_c2d;
    if ((a >= 8 && a <= 13) || (a >= 16 && a <= 21)) return m_reg[a];
    return 32'h0;
  endfunction

  function automatic logic [1:0] m_match();
    logic [1:0] r;
    for (int u = 0; u < 2; u++) begin
      int b = 8 * (u + 1);
      r[u] = (((bus_addr ^ m_reg[b])   & ~m_reg[b+1]) == 0) &&
             (((bus_data ^ m_reg[b+2]) & ~m_reg[b+3]) == 0) &&
             (((bus_ctrl ^ m_reg[b+4]) & ~m_reg[b+5]) == 0);
    end
    return r;
  endfunction

  task automatic m_clear();
    m_sr = '0; m_src = '0; m_c2d = '0; m_d2c = '0; m_wait = 0; m_pend = 0;
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
  endtask

  task automatic m_tick();
    logic [37:0] nsr;
    logic [31:0] rv;
    int a;
    if (!rst_n || !trst_n) begin m_clear(); return; end
    nsr = m_sr;
    rv = m_read(int'(m_src));
    if (cap) nsr = {6'b0, rv};
    else if (sh) nsr = {tdi, m_sr[37:1]};
    a = int'(m_sr[36:32]);
    if (m_pend && d2c_ready) m_pend = 0;
    if (cap && m_src == 5) m_wait = 0;
    else if (c2d_valid && !m_wait) begin m_c2d = c2d_data; m_wait = 1; end
    if (upd && !m_sr[37]) m_src = m_sr[36:32];
    if (upd && m_sr[37]) begin
      if (a == 0 || (a >= 8 && a <= 13) || (a >= 16 && a <= 21)) m_reg[a] = m_sr[31:0];
      else if (a == 5) begin m_d2c = m_sr[31:0]; m_pend = 1; end
    end
    m_sr = nsr;
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic compare_all();
    check("R1 tdo", 64'(tdo), 64'(m_sr[0]));
    check("R8 c2d_ready", 64'(c2d_ready), 64'(!m_wait));
    check("R7 d2c_valid", 64'(d2c_valid), 64'(m_pend));
    check("R7 d2c_data", 64'(d2c_data), 64'(m_d2c));
    check("R2 dbg_ctrl", 64'(dbg_ctrl), 64'(m_reg[0]));
    check("R11 wp_match", 64'(wp_match), 64'(m_match()));
  endtask

  task automatic step();
    m_tick();
    @(posedge clk);
    @(negedge clk);
    cyc++;
    compare_all();
  endtask

  task automatic scan(input logic [37:0] w, output logic [37:0] o, input bit rdy_at_upd = 0);
    cap = 1; step(); cap = 0;
    for (int i = 0; i < 38; i++) begin
      o[i] = tdo; tdi = w[i]; sh = 1; step();
    end
    sh = 0;
    if (rdy_at_upd) d2c_ready = 1;
    upd = 1; step(); upd = 0; d2c_ready = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    logic [37:0] o;
    scan({1'b1, a, d}, o);
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    logic [37:0] o;
    scan({1'b0, a, 32'h0}, o);
    scan({1'b0, 5'd4, 32'h0}, o);
    check("R3 capture upper bits zero", 64'(o[37:32]), 64'h0);
    d = o[31:0];
  endtask

  task automatic core_push(input logic [31:0] d);
    c2d_data = d; c2d_valid = 1; step(); c2d_valid = 0;
  endtask

  initial begin
    int limit = 150000;
    @(posedge clk);
    while (cyc < limit) @(posedge clk);
    bad++; total++;
    $display("FAIL R10 watchdog expired actual=%0d expected<%0d", cyc, limit);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [37:0] o;
    logic t0;
    m_clear();
    @(negedge clk);
    step(); step();
    rst_n = 1; step();
    check("R10 reset d2c_valid", 64'(d2c_valid), 64'h0);
    check("R10 reset c2d_ready", 64'(c2d_ready), 64'h1);
    check("R10 reset dbg_ctrl", 64'(dbg_ctrl), 64'h0);
    check("R11 zero regs match zero bus", 64'(wp_match), 64'h3);

    wr(5'h00, 32'hDEAD_BEEF);
    check("R2 ctrl write", 64'(dbg_ctrl), 64'hDEAD_BEEF);
    rd(5'h00, v); check("R3 ctrl readback", 64'(v), 64'hDEAD_BEEF);

    dbg_status = 32'h1234_5678;
    rd(5'h01, v); check("R4 status read", 64'(v), 64'h1234_5678);
    wr(5'h01, 32'hFFFF_0000);
    rd(5'h01, v); check("R4 status write ignored", 64'(v), 64'h1234_5678);

    rd(5'h04, v); check("R5 mailbox ctrl idle", 64'(v), 64'h3000_0000);
    wr(5'h04, 32'h0000_0003);
    rd(5'h04, v); check("R5 mailbox ctrl write ignored", 64'(v), 64'h3000_0000);

    core_push(32'hCAFE_F00D);
    check("R8 ready drops after push", 64'(c2d_ready), 64'h0);
    rd(5'h04, v); check("R5 waiting flag", 64'(v), 64'h3000_0001);
    check("R6 control capture harmless", 64'(c2d_ready), 64'h0);
    rd(5'h05, v); check("R6 mailbox data read", 64'(v), 64'hCAFE_F00D);
    check("R6 data capture frees mailbox", 64'(c2d_ready), 64'h1);

    core_push(32'h1111_2222);
    scan({1'b0, 5'd5, 32'h0}, o);
    scan({1'b0, 5'd5, 32'h0}, o);
    check("R6 first data read", 64'(o[31:0]), 64'h1111_2222);
    core_push(32'h3333_4444);
    check("R8 refill accepted", 64'(c2d_ready), 64'h0);
    scan({1'b0, 5'd4, 32'h0}, o);
    check("R6 hidden second read value", 64'(o[31:0]), 64'h3333_4444);
    check("R6 hidden second read clears", 64'(c2d_ready), 64'h1);

    wr(5'h05, 32'hA5A5_5A5A);
    check("R7 d2c posted", 64'(d2c_valid), 64'h1);
    check("R7 d2c data", 64'(d2c_data), 64'hA5A5_5A5A);
    rd(5'h04, v); check("R5 pending flag", 64'(v), 64'h3000_0002);
    d2c_ready = 1; step(); d2c_ready = 0;
    check("R7 core take clears", 64'(d2c_valid), 64'h0);
    wr(5'h05, 32'h0000_0001);
    scan({1'b1, 5'd5, 32'h0BAD_F00D}, o, 1'b1);
    check("R7 write wins over take", 64'(d2c_valid), 64'h1);
    check("R7 write wins data", 64'(d2c_data), 64'h0BAD_F00D);
    d2c_ready = 1; step(); d2c_ready = 0;

    wr(5'h07, 32'hFFFF_FFFF);
    rd(5'h07, v); check("R9 unmapped 0x07 reads zero", 64'(v), 64'h0);
    wr(5'h0E, 32'h0000_0001);
    rd(5'h0E, v); check("R9 unmapped 0x0E reads zero", 64'(v), 64'h0);
    wr(5'h1F, 32'h5555_5555);
    rd(5'h1F, v); check("R9 unmapped 0x1F reads zero", 64'(v), 64'h0);
    check("R9 ctrl untouched", 64'(dbg_ctrl), 64'hDEAD_BEEF);

    wr(5'h08, 32'h0000_1000); wr(5'h09, 32'h0000_00FF);
    wr(5'h0B, 32'hFFFF_FFFF); wr(5'h0D, 32'hFFFF_FFFF);
    bus_data = 32'h7777_0000; bus_ctrl = 32'h0000_0042;
    bus_addr = 32'h0000_10AB; step();
    check("R11 unit0 masked address hit", 64'(wp_match[0]), 64'h1);
    bus_addr = 32'h0000_11AB; step();
    check("R11 unit0 address miss", 64'(wp_match[0]), 64'h0);
    wr(5'h10, 32'h0000_11AB); wr(5'h13, 32'hFFFF_FFFF); wr(5'h15, 32'hFFFF_FFFF);
    step();
    check("R11 unit1 hit only", 64'(wp_match), 64'h2);
    rd(5'h10, v); check("R4 unit1 address value slot", 64'(v), 64'h0000_11AB);
    rd(5'h11, v); check("R4 unit1 address mask slot", 64'(v), 64'h0);
    rd(5'h0B, v); check("R4 unit0 data mask slot", 64'(v), 64'hFFFF_FFFF);
    bus_addr = 32'h0000_1000;
    wr(5'h0B, 32'h0); wr(5'h0A, 32'h0000_0055);
    bus_data = 32'h0000_0055; step();
    check("R11 data field hit", 64'(wp_match[0]), 64'h1);
    bus_data = 32'h0000_0054; step();
    check("R11 data field miss", 64'(wp_match[0]), 64'h0);

    t0 = tdo;
    for (int i = 0; i < 6; i++) begin tdi = i[0]; step(); end
    check("R10 idle hold tdo", 64'(tdo), 64'(t0));

    trst_n = 0; step(); trst_n = 1; step();
    check("R10 trst clears ctrl", 64'(dbg_ctrl), 64'h0);
    check("R10 trst clears pending", 64'(d2c_valid), 64'h0);
    rd(5'h04, v); check("R10 version kept after trst", 64'(v), 64'h3000_0000);
    rd(5'h08, v); check("R10 watchpoint cleared", 64'(v), 64'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule